// File: doc/BRIEF.md
# NAND Flash Target Bus Controller

This block models the device side of a byte-wide raw NAND flash bus. Each write or read strobe is qualified by chip enable and by the command and address latch enables. A write is sorted into a command byte, an address byte or a data byte. A small state machine then runs an operation through its command, address-collection and data phases. Reads return page-buffer bytes, identification bytes or the status byte, depending on the phase. Outside those phases a read returns zero.

A single-page internal buffer sits between the bus and a small internal page array. A page read copies one array page into the buffer. A program copies the buffer into one array page. Array timing and protection are not modelled, so the ready/busy output always reports ready. Bus errors do not stop the device. A byte that breaks the expected order drops the pending operation and sets a sticky fail flag in the status byte.

Top module: `nand_target_ctrl`

## Requirements
- R1: While `ce_i` is low, writes change nothing and `dout_o` is 0x00 on every read.
- R2: A read with `ale_i` or `cle_i` high returns 0x00 and does not advance any counter or change the phase. A write with both `ale_i` and `cle_i` high is ignored.
- R3: Command 0xFF is accepted in every phase. It returns the device to idle and clears the fail flag.
- R4: The number of address bytes depends on the operation. Page read (0x00) and program (0x80) take `PG_ADDR_BYTES` bytes: first the column byte, then the row byte, then any high bytes, which are ignored. Random data output (0x05) takes `PG_ADDR_BYTES - ROW_BYTES` column bytes. ID read (0x90) takes 1 byte.
- R5: An address byte that arrives when no address byte is expected, including one beyond the expected count, sets the fail flag and returns to idle.
- R6: A known command that arrives while an address byte, a data byte or the second command byte is still pending sets the fail flag. That command then starts a new operation.
- R7: Command 0x70 enters status output. Each read returns a status byte with bit 7 = 1 (not write-protected), bit 6 = 1 (ready) and bit 0 = the fail flag, and the phase does not change however many times it is read.
- R8: After 0x90 and its address byte, reads return ID0, ID1, ID2 and ID3 in that order, then 0x00. Only ID0 and ID1 are returned when ID2 and ID3 are both 0xFF.
- R9: 0x00 + address + 0x30 outputs the addressed page starting at the column. Reads past the page end return 0x00. 0x80 + address + data + 0x10 writes the buffer, starting at the column, into the addressed page. Data bytes beyond the page end are ignored without an error.
- R10: A data byte written outside the program data phase sets the fail flag and returns to idle.
- R11: With `BUS16` set, each data byte written or read moves the byte position by 2.
- R12: With `AUTO_INC` set, reading the last byte of a page resets the position to 0 and advances the row, unless the row is the last page. The buffer is then reloaded from the array without a new command.
- R13: 0x05 + column + 0xE0 during output resumes output at the new column on the same row, from the buffer as it already stands.
- R14: Command bytes other than 0x00, 0x30, 0x80, 0x10, 0x05, 0xE0, 0x70, 0x90 and 0xFF are ignored, and `rdy_o` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe, one byte per cycle |
| din_i | input | 8 | Byte written by the host |
| dout_o | output | 8 | Byte returned during a read strobe, 0x00 otherwise |
| rdy_o | output | 1 | Ready/busy, held ready |

## Verification
The main flow is driven with well-ordered sequences: a program that overruns the page, a page read that runs past the page end, random output to a new column, and the ID and status reads. A right answer in each proves that the byte position and the row were handled correctly. The same flow is also driven with out-of-order patterns: a command in the middle of an address, a stray address or data byte, an address byte beyond the expected count, and an unknown command. A failed status after each error pattern, and a clean status after each legal pattern, separate the error cases from the legal ones. A second instance with the wide-bus and auto-increment options reads across a page boundary and past the last page, which shows the step of 2, the advance of the row and the stop at the last page.

// File: rtl/nand_target_ctrl.sv
module nand_target_ctrl #(
  parameter int PAGE_BYTES = 8,
  parameter int PAGES = 4,
  parameter int PG_ADDR_BYTES = 3,
  parameter int ROW_BYTES = 2,
  parameter bit BUS16 = 1'b0,
  parameter bit AUTO_INC = 1'b0,
  parameter logic [7:0] ID0 = 8'hEC,
  parameter logic [7:0] ID1 = 8'hDA,
  parameter logic [7:0] ID2 = 8'h10,
  parameter logic [7:0] ID3 = 8'h95
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] din_i,
  output logic [7:0] dout_o,
  output logic       rdy_o
);
  localparam int CW = $clog2(PAGE_BYTES);
  localparam int RW = $clog2(PAGES);
  localparam int NW = CW + 2;
  localparam logic [NW-1:0] NBYTES = NW'(PAGE_BYTES);
  localparam logic [NW-1:0] STEP = BUS16 ? NW'(2) : NW'(1);
  localparam logic [NW-1:0] NID = (ID2 != 8'hFF || ID3 != 8'hFF) ? NW'(4) : NW'(2);
  localparam logic [2:0] N_PAGE = 3'(PG_ADDR_BYTES);
  localparam logic [2:0] N_COL = 3'(PG_ADDR_BYTES - ROW_BYTES);
  localparam logic [31:0] IDS = {ID3, ID2, ID1, ID0};

  localparam logic [7:0] C_READ1 = 8'h00, C_READ2 = 8'h30;
  localparam logic [7:0] C_PROG1 = 8'h80, C_PROG2 = 8'h10;
  localparam logic [7:0] C_RND1 = 8'h05, C_RND2 = 8'hE0;
  localparam logic [7:0] C_STAT = 8'h70, C_ID = 8'h90, C_RESET = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD2, S_DIN, S_DOUT, S_ID, S_STAT} state_t;
  typedef enum logic [1:0] {OP_RD, OP_PRG, OP_RND, OP_ID} op_t;

  state_t                  state_q;
  op_t                     op_q;
  logic                    fail_q;
  logic [2:0]              acnt_q, anum_q;
  logic [NW-1:0]           cnt_q;
  logic [CW-1:0]           col_q;
  logic [RW-1:0]           row_q;
  logic [PAGE_BYTES*8-1:0] pbuf_q;
  logic [PAGE_BYTES*8-1:0] mem_q [PAGES];

  wire wr_ok = wr_i & ce_i & ~(ale_i & cle_i);
  wire rd_ok = rd_i & ~wr_i & ce_i & ~ale_i & ~cle_i;
  wire [CW+2:0] bsel = {cnt_q[CW-1:0], 3'b000};
  wire [7:0] buf_byte = pbuf_q[bsel +: 8];
  wire [7:0] id_byte = IDS[{cnt_q[1:0], 3'b000} +: 8];
  wire [7:0] status = {2'b11, 5'b00000, fail_q};
  wire [NW-1:0] cnt_nx = cnt_q + STEP;
  wire [2:0] acnt_nx = acnt_q + 3'd1;
  wire last_pg = (int'(row_q) + 1 >= PAGES);
  wire [RW-1:0] row_nx = last_pg ? row_q : row_q + 1'b1;
  wire known = din_i inside {C_READ1, C_READ2, C_PROG1, C_PROG2, C_RND1, C_RND2, C_STAT, C_ID};
  wire pend = state_q inside {S_ADDR, S_CMD2, S_DIN};

  assign rdy_o = 1'b1;

  always_comb begin
    dout_o = 8'h00;
    if (rd_ok) begin
      case (state_q)
        S_STAT: dout_o = status;
        S_DOUT: if (cnt_q < NBYTES) dout_o = buf_byte;
        S_ID:   if (cnt_q < NID) dout_o = id_byte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_RD;
      fail_q  <= 1'b0;
      acnt_q  <= '0;
      anum_q  <= '0;
      cnt_q   <= '0;
      col_q   <= '0;
      row_q   <= '0;
      pbuf_q  <= '0;
      for (int p = 0; p < PAGES; p++) mem_q[p] <= '0;
    end else if (wr_ok && cle_i) begin
      if (din_i == C_RESET) begin
        state_q <= S_IDLE;
        fail_q  <= 1'b0;
      end else if (known) begin
        if (state_q == S_CMD2 && op_q == OP_RD && din_i == C_READ2) begin
          pbuf_q  <= mem_q[row_q];
          cnt_q   <= NW'(col_q);
          state_q <= S_DOUT;
        end else if (state_q == S_CMD2 && op_q == OP_RND && din_i == C_RND2) begin
          cnt_q   <= NW'(col_q);
          state_q <= S_DOUT;
        end else if (state_q == S_DIN && din_i == C_PROG2) begin
          mem_q[row_q] <= pbuf_q;
          fail_q  <= 1'b0;
          state_q <= S_IDLE;
        end else begin
          if (pend) fail_q <= 1'b1;
          acnt_q <= '0;
          cnt_q  <= '0;
          case (din_i)
            C_READ1: begin state_q <= S_ADDR; op_q <= OP_RD;  anum_q <= N_PAGE; end
            C_PROG1: begin state_q <= S_ADDR; op_q <= OP_PRG; anum_q <= N_PAGE; end
            C_RND1:  begin state_q <= S_ADDR; op_q <= OP_RND; anum_q <= N_COL;  end
            C_ID:    begin state_q <= S_ADDR; op_q <= OP_ID;  anum_q <= 3'd1;   end
            C_STAT:  state_q <= S_STAT;
            default: state_q <= S_IDLE;
          endcase
        end
      end
    end else if (wr_ok && ale_i) begin
      if (state_q != S_ADDR) begin
        fail_q  <= 1'b1;
        state_q <= S_IDLE;
      end else begin
        if (acnt_q == 3'd0 && op_q != OP_ID) col_q <= din_i[CW-1:0];
        if (acnt_q == N_COL && (op_q == OP_RD || op_q == OP_PRG)) row_q <= din_i[RW-1:0];
        acnt_q <= acnt_nx;
        if (acnt_nx == anum_q) begin
          case (op_q)
            OP_PRG:  begin state_q <= S_DIN; cnt_q <= NW'(col_q); end
            OP_ID:   begin state_q <= S_ID;  cnt_q <= '0; end
            default: state_q <= S_CMD2;
          endcase
        end
      end
    end else if (wr_ok) begin
      if (state_q != S_DIN) begin
        fail_q  <= 1'b1;
        state_q <= S_IDLE;
      end else if (cnt_q < NBYTES) begin
        pbuf_q[bsel +: 8] <= din_i;
        cnt_q <= cnt_nx;
      end
    end else if (rd_ok) begin
      if (state_q == S_DOUT && cnt_q < NBYTES) begin
        if (AUTO_INC && cnt_nx >= NBYTES) begin
          cnt_q  <= '0;
          row_q  <= row_nx;
          pbuf_q <= mem_q[row_nx];
        end else begin
          cnt_q <= cnt_nx;
        end
      end else if (state_q == S_ID && cnt_q < NID) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module nand_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_i,
  input logic       cle_i,
  input logic       ale_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] din_i,
  input logic [7:0] dout_o,
  input logic [2:0] st,
  input logic       fl
);
  localparam logic [2:0] K_IDLE = 3'd0, K_ADDR = 3'd1, K_DIN = 3'd3, K_STAT = 3'd6;

  // R1
  ce_off_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |-> dout_o == 8'h00);
  // R1
  ce_off_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && wr_i) |=> ($stable(st) && $stable(fl)));
  // R2
  latch_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && (ale_i || cle_i)) |-> dout_o == 8'h00);
  // R2
  latch_read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && (ale_i || cle_i)) |=> $stable(st));
  // R3
  reset_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ce_i && cle_i && !ale_i && din_i == 8'hFF) |=> (st == K_IDLE && !fl));
  // R5
  stray_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ce_i && ale_i && !cle_i && st != K_ADDR) |=> (st == K_IDLE && fl));
  // R10
  stray_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ce_i && !ale_i && !cle_i && st != K_DIN) |=> (st == K_IDLE && fl));
  // R7
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && ce_i && !ale_i && !cle_i && st == K_STAT) |=> (st == K_STAT && $stable(fl)));
endmodule

bind nand_target_ctrl nand_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .cle_i(cle_i), .ale_i(ale_i),
  .wr_i(wr_i), .rd_i(rd_i), .din_i(din_i), .dout_o(dout_o), .st(state_q), .fl(fail_q)
);

// File: tb/nand_target_ctrl_tb_top.sv
`timescale 1ns/1ps
module nand_target_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_a = 1'b1, ce_b = 1'b0;
  logic cle = 1'b0, ale = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout_a, dout_b;
  logic rdy_a, rdy_b;
  logic sel_b = 1'b0;
  logic done = 1'b0;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  nand_target_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce_a), .cle_i(cle), .ale_i(ale),
    .wr_i(wr), .rd_i(rd), .din_i(din), .dout_o(dout_a), .rdy_o(rdy_a));

  nand_target_ctrl #(.BUS16(1'b1), .AUTO_INC(1'b1), .ID0(8'h98), .ID1(8'hF1),
                     .ID2(8'hFF), .ID3(8'hFF)) dut16_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce_b), .cle_i(cle), .ale_i(ale),
    .wr_i(wr), .rd_i(rd), .din_i(din), .dout_o(dout_b), .rdy_o(rdy_b));

  // kind: 0 command, 1 address, 2 data, 3 read; then byte, expected read, requirement
  localparam int NV = 64;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0,8'h80,8'h00,4'd9}, {2'd1,8'h00,8'h00,4'd9}, {2'd1,8'h02,8'h00,4'd9}, {2'd1,8'h00,8'h00,4'd9},
    {2'd2,8'h10,8'h00,4'd9}, {2'd2,8'h11,8'h00,4'd9}, {2'd2,8'h12,8'h00,4'd9}, {2'd2,8'h13,8'h00,4'd9},
    {2'd2,8'h14,8'h00,4'd9}, {2'd2,8'h15,8'h00,4'd9}, {2'd2,8'h16,8'h00,4'd9}, {2'd2,8'h17,8'h00,4'd9},
    {2'd2,8'h99,8'h00,4'd9}, {2'd0,8'h10,8'h00,4'd9},
    // R7 status repeat
    {2'd0,8'h70,8'h00,4'd7}, {2'd3,8'h00,8'hC0,4'd7}, {2'd3,8'h00,8'hC0,4'd7},
    // R9 page read from column 6, past end is zero
    {2'd0,8'h00,8'h00,4'd9}, {2'd1,8'h06,8'h00,4'd9}, {2'd1,8'h02,8'h00,4'd9}, {2'd1,8'h00,8'h00,4'd9},
    {2'd0,8'h30,8'h00,4'd9}, {2'd3,8'h00,8'h16,4'd9}, {2'd3,8'h00,8'h17,4'd9}, {2'd3,8'h00,8'h00,4'd9},
    // R13 random output
    {2'd0,8'h05,8'h00,4'd13}, {2'd1,8'h03,8'h00,4'd13}, {2'd0,8'hE0,8'h00,4'd13},
    {2'd3,8'h00,8'h13,4'd13}, {2'd3,8'h00,8'h14,4'd13},
    // R8 four ID bytes
    {2'd0,8'h90,8'h00,4'd8}, {2'd1,8'h00,8'h00,4'd8}, {2'd3,8'h00,8'hEC,4'd8}, {2'd3,8'h00,8'hDA,4'd8},
    {2'd3,8'h00,8'h10,4'd8}, {2'd3,8'h00,8'h95,4'd8}, {2'd3,8'h00,8'h00,4'd8},
    // R4 legal counts leave status clean
    {2'd0,8'h70,8'h00,4'd4}, {2'd3,8'h00,8'hC0,4'd4},
    // R10 stray data
    {2'd2,8'h42,8'h00,4'd10}, {2'd0,8'h70,8'h00,4'd10}, {2'd3,8'h00,8'hC1,4'd10},
    // R3 reset clears fail
    {2'd0,8'hFF,8'h00,4'd3}, {2'd0,8'h70,8'h00,4'd3}, {2'd3,8'h00,8'hC0,4'd3},
    // R6 command mid-address
    {2'd0,8'h00,8'h00,4'd6}, {2'd1,8'h00,8'h00,4'd6}, {2'd0,8'h70,8'h00,4'd6}, {2'd3,8'h00,8'hC1,4'd6},
    {2'd0,8'hFF,8'h00,4'd6},
    // R5 stray address
    {2'd1,8'h05,8'h00,4'd5}, {2'd0,8'h70,8'h00,4'd5}, {2'd3,8'h00,8'hC1,4'd5}, {2'd0,8'hFF,8'h00,4'd5},
    {2'd0,8'h70,8'h00,4'd5}, {2'd3,8'h00,8'hC0,4'd5},
    // R14 unknown command
    {2'd0,8'h3C,8'h00,4'd14}, {2'd3,8'h00,8'hC0,4'd14},
    // R4 second address byte after ID address fails
    {2'd0,8'h90,8'h00,4'd4}, {2'd1,8'h00,8'h00,4'd4}, {2'd1,8'h00,8'h00,4'd4}, {2'd0,8'h70,8'h00,4'd4},
    {2'd3,8'h00,8'hC1,4'd4}, {2'd0,8'hFF,8'h00,4'd4}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // kinds 4: read with ALE high, 5: write with ALE and CLE both high
  task automatic bus(input int k, input logic [7:0] b, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cle = (k == 0 || k == 5);
    ale = (k == 1 || k == 4 || k == 5);
    wr  = (k <= 2 || k == 5);
    rd  = (k == 3 || k == 4);
    din = b;
    #1;
    if (k == 3 || k == 4) check(sel_b ? dout_b : dout_a, exp, tag);
    @(negedge clk);
    cle = 1'b0; ale = 1'b0; wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state: idle read returns zero; R14 ready held
    bus(3, 8'h00, 8'h00, "reset idle read");
    check({7'd0, rdy_a}, 8'h01, "R14 rdy");
    check({7'd0, rdy_b}, 8'h01, "R14 rdy wide");

    for (int i = 0; i < NV; i++)
      bus(int'(VEC[i][21:20]), VEC[i][19:12], VEC[i][11:4], $sformatf("R%0d vec %0d", VEC[i][3:0], i));

    // R2: latched read returns zero and holds; both-latch write ignored
    bus(0, 8'h70, 8'h00, "R2");
    bus(4, 8'h00, 8'h00, "R2 ale read");
    bus(3, 8'h00, 8'hC0, "R2 status after ale read");
    bus(5, 8'h00, 8'h00, "R2");
    bus(3, 8'h00, 8'hC0, "R2 both-latch write ignored");

    // R1: chip disabled
    ce_a = 1'b0;
    bus(2, 8'h42, 8'h00, "R1");
    bus(3, 8'h00, 8'h00, "R1 disabled read");
    ce_a = 1'b1;
    bus(3, 8'h00, 8'hC0, "R1 write ignored");

    // wide bus, auto-increment instance
    ce_a = 1'b0; ce_b = 1'b1; sel_b = 1'b1;
    bus(0, 8'h80, 8'h00, "R11"); bus(1, 8'h00, 8'h00, "R11"); bus(1, 8'h02, 8'h00, "R11"); bus(1, 8'h00, 8'h00, "R11");
    bus(2, 8'hB1, 8'h00, "R11"); bus(2, 8'hB2, 8'h00, "R11"); bus(2, 8'hB3, 8'h00, "R11"); bus(2, 8'hB4, 8'h00, "R11");
    bus(0, 8'h10, 8'h00, "R11");
    bus(0, 8'h80, 8'h00, "R11"); bus(1, 8'h00, 8'h00, "R11"); bus(1, 8'h03, 8'h00, "R11"); bus(1, 8'h00, 8'h00, "R11");
    bus(2, 8'h01, 8'h00, "R11"); bus(2, 8'h02, 8'h00, "R11"); bus(2, 8'h03, 8'h00, "R11"); bus(2, 8'h04, 8'h00, "R11");
    bus(2, 8'h05, 8'h00, "R9");
    bus(0, 8'h10, 8'h00, "R11");
    bus(0, 8'h00, 8'h00, "R12"); bus(1, 8'h04, 8'h00, "R12"); bus(1, 8'h02, 8'h00, "R12"); bus(1, 8'h00, 8'h00, "R12");
    bus(0, 8'h30, 8'h00, "R12");
    bus(3, 8'h00, 8'hB3, "R11 wide byte 4");
    bus(3, 8'h00, 8'hB4, "R11 wide byte 6");
    bus(3, 8'h00, 8'h01, "R12 next page");
    bus(3, 8'h00, 8'h02, "R12");
    bus(3, 8'h00, 8'h03, "R12");
    bus(3, 8'h00, 8'h04, "R9 excess data ignored");
    bus(3, 8'h00, 8'h01, "R12 last page holds");
    bus(0, 8'h90, 8'h00, "R8"); bus(1, 8'h00, 8'h00, "R8");
    bus(3, 8'h00, 8'h98, "R8 two-id first");
    bus(3, 8'h00, 8'hF1, "R8 two-id second");
    bus(3, 8'h00, 8'h00, "R8 two-id end");

    // R1: first instance saw none of the traffic above
    ce_b = 1'b0; ce_a = 1'b1; sel_b = 1'b0;
    bus(0, 8'h70, 8'h00, "R1");
    bus(3, 8'h00, 8'hC0, "R1 untouched while disabled");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule